// File: doc/BRIEF.md
# Base and Bounds Address Checker

This block sits between a user program's address generator and memory. It holds two relocation windows: one used for instruction fetches, the other for data accesses. Each window has a base register and a span register. Every request carries a logical offset and a fetch/data flag. The block checks the offset against the span of the matching window and adds the window's base to form a physical address. One cycle later it returns either that physical address or a protection fault with a cause code. The kernel can move a program by changing the base registers, and the program itself stays the same.

The four window registers are loaded through a configuration port that carries a privilege flag. A write from user mode leaves every register unchanged and raises a one-cycle fault flag. After reset both spans are zero, so every access faults until privileged software programs the windows. Code and data have separate windows, so the data window can be set to exclude the program's own instructions.

Top module: `bb_addr_checker`

## Requirements
- R1: After reset all four window registers are zero. Every access then faults with cause 1, and rsp_valid, rsp_fault, rsp_cause, rsp_paddr and cfg_fault are all zero until a request or a configuration write arrives.
- R2: A request sampled with req_valid high at a clock edge produces rsp_valid high in the cycle after that edge. In a cycle with no response, rsp_valid, rsp_fault, rsp_cause and rsp_paddr are zero.
- R3: A request with req_fetch=1 is checked and relocated only against the code window. A request with req_fetch=0 is checked only against the data window.
- R4: When the offset is at most span-1 and no wrap occurs, the response has rsp_fault=0, rsp_cause=0 and rsp_paddr = base + offset. Offset 0 is the lowest legal offset and span-1 the highest.
- R5: An offset equal to or greater than the span faults with rsp_cause=1. A span of zero makes every offset fault.
- R6: An in-span offset whose sum base + offset does not fit in AW bits faults with rsp_cause=2, so a physical address below the base is never produced. When both conditions apply, cause 1 takes precedence.
- R7: While rsp_fault is high, rsp_paddr is zero.
- R8: A write with cfg_we=1 and cfg_priv=1 loads cfg_wdata into the register chosen by cfg_sel: 0 is code base, 1 is code span, 2 is data base, 3 is data span. A request in the next cycle uses the new value.
- R9: A write with cfg_we=1 and cfg_priv=0 changes no register. It sets cfg_fault high for exactly the following cycle. cfg_fault is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_off | input | AW | Logical offset of the access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | 1 = writer is in privileged mode |
| cfg_sel | input | 2 | Window register select |
| cfg_wdata | input | AW | Configuration write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_fault | output | 1 | Protection fault |
| rsp_cause | output | 2 | 0 none, 1 beyond span, 2 address wrap |
| rsp_paddr | output | AW | Relocated physical address, zero on fault |
| cfg_fault | output | 1 | Rejected user-mode configuration write |

## Verification
On a 6-bit configuration, every offset is swept for both access types under several window settings. These settings are: an empty window, a small window at base 0, code and data windows of different sizes, and a window placed high enough that in-span offsets wrap. Together they separate a span compare that is off by one from a correct one, and a fetch that uses the data window from one that uses its own. They also separate cause 1 from cause 2 where the two overlap. Directed accesses cover the lowest legal offset, the highest legal offset, one past the span, and a data access at an offset that is only legal in the code window. User-mode writes are followed by accesses whose results show that no register moved.

// File: rtl/bb_pkg.sv
// Shared types for the base and bounds address checker.
// Assumes two windows: index 0 serves fetches, index 1 serves data.
package bb_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_SPAN = 2'd1,
        CAUSE_WRAP = 2'd2
    } cause_e;

    localparam int unsigned NWIN     = 2;
    localparam int unsigned WIN_CODE = 0;
    localparam int unsigned WIN_DATA = 1;

    // Configuration select layout: bit 1 picks the window, bit 0 picks span over base.
    localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/bb_window_regs.sv
// Window register file: one base and one span register per window.
// Only privileged writes land. A user-mode write is dropped and raises
// cfg_fault for one cycle. Assumes synchronous active-low reset.
module bb_window_regs
    import bb_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_priv,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [AW-1:0]             cfg_wdata,
    output logic [NWIN-1:0][AW-1:0]   win_base,
    output logic [NWIN-1:0][AW-1:0]   win_span,
    output logic                      cfg_fault
);

    logic write_ok;
    logic write_bad;

    // Split the strobe into accepted and rejected writes.
    always_comb begin
        write_ok  = cfg_we && cfg_priv;
        write_bad = cfg_we && !cfg_priv;
    end

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic hit_base;
        logic hit_span;

        // Decode which register of this window the write addresses.
        always_comb begin
            hit_base = write_ok && (cfg_sel[1] == w[0]) && !cfg_sel[0];
            hit_span = write_ok && (cfg_sel[1] == w[0]) &&  cfg_sel[0];
        end

        // Base register of this window.
        always_ff @(posedge clk) begin
            if (!rst_n)        win_base[w] <= '0;
            else if (hit_base) win_base[w] <= cfg_wdata;
        end

        // Span register of this window.
        always_ff @(posedge clk) begin
            if (!rst_n)        win_span[w] <= '0;
            else if (hit_span) win_span[w] <= cfg_wdata;
        end
    end

    // One-cycle flag for a rejected user-mode write.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_fault <= 1'b0;
        else        cfg_fault <= write_bad;
    end

endmodule

// File: rtl/bb_window_check.sv
// Combinational check of one offset against one window.
// Legal when offset < span and base + offset fits in AW bits.
// Span failure is reported ahead of wrap. Assumes unsigned offsets.
module bb_window_check
    import bb_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] off,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] span,
    output cause_e        cause,
    output logic [AW-1:0] paddr
);

    logic [AW:0] sum;
    logic        in_span;
    logic        wraps;

    // Widened sum so the carry out of the relocation is visible.
    always_comb begin
        sum     = {1'b0, base} + {1'b0, off};
        in_span = off < span;
        wraps   = sum[AW];
    end

    // Pick the cause and pass the address only when legal.
    always_comb begin
        if (!in_span) begin
            cause = CAUSE_SPAN;
            paddr = '0;
        end else if (wraps) begin
            cause = CAUSE_WRAP;
            paddr = '0;
        end else begin
            cause = CAUSE_NONE;
            paddr = sum[AW-1:0];
        end
    end

endmodule

// File: rtl/bb_result_reg.sv
// Response stage: selects the checked result for the request's window
// and registers it, giving one cycle of latency. All outputs are zero
// in a cycle with no response.
module bb_result_reg
    import bb_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_fetch,
    input  cause_e  [NWIN-1:0]      win_cause,
    input  logic [NWIN-1:0][AW-1:0] win_paddr,
    output logic                    rsp_valid,
    output logic                    rsp_fault,
    output logic [1:0]              rsp_cause,
    output logic [AW-1:0]           rsp_paddr
);

    cause_e        sel_cause;
    logic [AW-1:0] sel_paddr;

    // Route the result of the window that matches the access type.
    always_comb begin
        if (req_fetch) begin
            sel_cause = win_cause[WIN_CODE];
            sel_paddr = win_paddr[WIN_CODE];
        end else begin
            sel_cause = win_cause[WIN_DATA];
            sel_paddr = win_paddr[WIN_DATA];
        end
    end

    // Register the response; idle cycles clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= 2'd0;
            rsp_paddr <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_fault <= (sel_cause != CAUSE_NONE);
            rsp_cause <= sel_cause;
            rsp_paddr <= sel_paddr;
        end
    end

endmodule

// File: rtl/bb_addr_checker.sv
// Base and bounds address checker top. It holds a code window and a
// data window. Each request is checked and relocated against the window
// of its own type, and the result appears one cycle later. Window
// registers load only through privileged configuration writes.
module bb_addr_checker
    import bb_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_fetch,
    input  logic [AW-1:0]    req_off,
    input  logic             cfg_we,
    input  logic             cfg_priv,
    input  logic [1:0]       cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [1:0]       rsp_cause,
    output logic [AW-1:0]    rsp_paddr,
    output logic             cfg_fault
);

    logic [NWIN-1:0][AW-1:0] win_base;
    logic [NWIN-1:0][AW-1:0] win_span;
    cause_e [NWIN-1:0]       win_cause;
    logic [NWIN-1:0][AW-1:0] win_paddr;

    bb_window_regs #(.AW(AW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_priv  (cfg_priv),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .win_base  (win_base),
        .win_span  (win_span),
        .cfg_fault (cfg_fault)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_chk
        bb_window_check #(.AW(AW)) chk_i (
            .off   (req_off),
            .base  (win_base[w]),
            .span  (win_span[w]),
            .cause (win_cause[w]),
            .paddr (win_paddr[w])
        );
    end

    bb_result_reg #(.AW(AW)) res_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_fetch (req_fetch),
        .win_cause (win_cause),
        .win_paddr (win_paddr),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_cause (rsp_cause),
        .rsp_paddr (rsp_paddr)
    );

endmodule

// File: rtl/bb_addr_checker_sva.sv
// Property checker for bb_addr_checker, attached with bind below.
// It observes the ports and the window registers.
module bb_addr_checker_sva #(
    parameter int unsigned AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_fetch,
    input logic              cfg_we,
    input logic              cfg_priv,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [1:0]        rsp_cause,
    input logic [AW-1:0]     rsp_paddr,
    input logic              cfg_fault,
    input logic [1:0][AW-1:0] win_base,
    input logic [1:0][AW-1:0] win_span
);

    logic [AW-1:0] own_span;

    // Span of the window that the current request must use.
    always_comb own_span = req_fetch ? win_span[0] : win_span[1];

    // R2: a request is answered in the next cycle.
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: with no request, the response is quiet.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_cause == 2'd0 && rsp_paddr == '0));

    // R7: no address is presented with a fault.
    a_r7_fault_no_paddr: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_paddr == '0);

    // R5: an empty own window always faults with cause 1.
    a_r5_empty_window_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && own_span == '0) |=> (rsp_fault && rsp_cause == 2'd1));

    // R6: the fault flag and the cause code agree.
    a_r6_cause_matches_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

    // R9: a user-mode write raises the flag next cycle.
    a_r9_user_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> cfg_fault);

    // R9: a user-mode write leaves every window register unchanged.
    a_r9_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> ($stable(win_base) && $stable(win_span)));

    // R9: the flag only follows a user-mode write.
    a_r9_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !cfg_priv) |=> !cfg_fault);

endmodule

bind bb_addr_checker bb_addr_checker_sva #(.AW(AW)) sva_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_fetch (req_fetch),
    .cfg_we    (cfg_we),
    .cfg_priv  (cfg_priv),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_paddr (rsp_paddr),
    .cfg_fault (cfg_fault),
    .win_base  (win_base),
    .win_span  (win_span)
);

// File: tb/bb_addr_checker_tb_top.sv
// Self-checking bench: a 6-bit configuration with full offset sweeps and
// directed corner cases. Expected results come from a bench-side model
// of the register values it wrote.
module bb_addr_checker_tb_top;

    localparam int AW  = 6;
    localparam int LIM = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_fetch = 1'b0;
    logic [AW-1:0] req_off = '0;
    logic          cfg_we = 1'b0;
    logic          cfg_priv = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          rsp_valid;
    logic          rsp_fault;
    logic [1:0]    rsp_cause;
    logic [AW-1:0] rsp_paddr;
    logic          cfg_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the four window registers: index 0 code, 1 data.
    int m_base [2];
    int m_span [2];

    always #2 clk = ~clk;

    bb_addr_checker #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_fetch(req_fetch), .req_off(req_off),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_paddr(rsp_paddr), .cfg_fault(cfg_fault)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Write one window register; the flag is checked in the next cycle.
    task automatic cfg_write(input bit priv, input int sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = priv; cfg_sel = 2'(sel); cfg_wdata = AW'(data);
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
        if (priv) begin
            if (sel[0]) m_span[sel[1]] = data;
            else        m_base[sel[1]] = data;
            check("R8 cfg_fault after privileged write", int'(cfg_fault), 0);
        end else begin
            check("R9 cfg_fault after user write", int'(cfg_fault), 1);
        end
    endtask

    task automatic set_windows(input int cb, input int cs, input int db, input int ds);
        cfg_write(1'b1, 0, cb);
        cfg_write(1'b1, 1, cs);
        cfg_write(1'b1, 2, db);
        cfg_write(1'b1, 3, ds);
    endtask

    // Issue one access and compare the next-cycle response with the model.
    task automatic access(input bit fetch, input int off, input string tag);
        int w, cause, paddr, sum;
        w = fetch ? 0 : 1;
        sum = m_base[w] + off;
        if (off >= m_span[w])  begin cause = 1; paddr = 0; end
        else if (sum >= LIM)   begin cause = 2; paddr = 0; end
        else                   begin cause = 0; paddr = sum; end
        @(negedge clk);
        req_valid = 1'b1; req_fetch = fetch; req_off = AW'(off);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R2 rsp_valid"}, int'(rsp_valid), 1);
        check({tag, " fault"}, int'(rsp_fault), int'(cause != 0));
        check({tag, " cause"}, int'(rsp_cause), cause);
        check({tag, " R7 paddr"}, int'(rsp_paddr), paddr);
    endtask

    task automatic sweep(input string tag);
        for (int f = 0; f < 2; f++)
            for (int o = 0; o < LIM; o++)
                access(f[0], o, tag);
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin m_base[i] = 0; m_span[i] = 0; end
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", int'(rsp_valid), 0);
        check("R1 cfg_fault in reset", int'(cfg_fault), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", int'(rsp_valid), 0);
        check("R1 rsp_paddr after reset", int'(rsp_paddr), 0);
        access(1'b1, 0, "R1 fetch after reset");
        access(1'b0, 0, "R1 data after reset");
        sweep("R1 R5 empty windows");

        // Code window: base 10, span 20. Data window: base 40, span 8.
        set_windows(10, 20, 40, 8);
        @(negedge clk);
        check("R2 idle rsp_valid", int'(rsp_valid), 0);
        access(1'b1, 0,  "R4 lowest legal fetch");
        check("R4 lowest paddr", int'(rsp_paddr), 10);
        access(1'b1, 19, "R4 highest legal fetch");
        check("R4 highest paddr", int'(rsp_paddr), 29);
        access(1'b1, 20, "R5 one past span fetch");
        access(1'b0, 7,  "R4 highest legal data");
        check("R3 data uses data base", int'(rsp_paddr), 47);
        access(1'b0, 12, "R3 data offset only legal in code window");
        check("R3 data window span rejects", int'(rsp_cause), 1);
        sweep("R3 R4 R5 split windows");

        // User writes must leave both windows as they were.
        cfg_write(1'b0, 1, 63);
        cfg_write(1'b0, 2, 0);
        access(1'b1, 20, "R9 span unchanged after user write");
        access(1'b0, 0,  "R9 base unchanged after user write");
        check("R9 data base kept", int'(rsp_paddr), 40);
        @(negedge clk);
        check("R9 flag lasts one cycle", int'(cfg_fault), 0);

        // Window placed high: in-span offsets wrap past the top.
        set_windows(50, 30, 0, 64 - 1);
        access(1'b1, 13, "R6 last fitting offset");
        check("R6 paddr 63", int'(rsp_paddr), 63);
        access(1'b1, 14, "R6 first wrapping offset");
        check("R6 wrap cause", int'(rsp_cause), 2);
        access(1'b1, 30, "R6 span takes precedence over wrap");
        sweep("R4 R5 R6 high window");

        // Back-to-back requests keep the one-cycle latency.
        set_windows(0, 5, 3, 4);
        @(negedge clk);
        req_valid = 1'b1; req_fetch = 1'b1; req_off = 6'd4;
        @(negedge clk);
        check("R2 back-to-back first paddr", int'(rsp_paddr), 4);
        req_fetch = 1'b0; req_off = 6'd3;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 back-to-back second paddr", int'(rsp_paddr), 6);
        sweep("R4 R5 small windows");

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule